// File: doc/BRIEF.md
# Subcode Symbol Serial Shifter

Once per frame this block captures one subcode symbol, which is eight channel bits P, Q, R, S, T, U, V and W. It then presents the symbol one bit at a time on a single serial data pin, and an external controller paces the bits with its own shift clock. The frame clock and the shift clock are both treated as asynchronous to the system clock. Each one passes through a two-flop synchroniser, and only its rising edge is used.

On the first bit position, a sync-flag input decides what appears in place of the P channel. When the flag is low, P is shown. When the flag is high, a separate sync indication (S0+S1) is shown. The flag is sampled at load time and applies to the whole frame.

A pulse counter tracks how many shift pulses have arrived since the last load. Once the symbol is used up, the output is held low. Extra pulses do not wrap the count or push in stale data.

Top module: `subcode_serializer`

## Requirements
- R1: After reset, and until the first load, `ser_o` is 0, even if shift pulses arrive.
- R2: A load happens only on a rising edge of `frame_clk_i`. `ser_o` shows the new first bit no later than 3 system clocks after that edge. A falling edge of `frame_clk_i` does not reload.
- R3: If `sync_flag_i` is 0 at load, the first bit shown is the P channel, `sym_i[7]`.
- R4: If `sync_flag_i` is 1 at load, the first bit shown is `sync_bit_i` instead of P.
- R5: Each rising edge of `shift_clk_i` advances the output by one bit. The order is `sym_i[6]` (Q) first and `sym_i[0]` (W) last.
- R6: After 8 or more shift pulses in a frame, `ser_o` stays 0. The pulse count saturates and does not wrap.
- R7: A load clears the pulse count, so a new frame starts again at its first bit even after an overrun.
- R8: Changes on `sym_i`, `sync_flag_i` or `sync_bit_i` between loads have no effect on `ser_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_clk_i | input | 1 | Asynchronous frame clock; a rising edge loads a symbol |
| shift_clk_i | input | 1 | Asynchronous external shift clock; a rising edge advances one bit |
| sym_i | input | 8 | Subcode symbol, bit 7 = P down to bit 0 = W |
| sync_flag_i | input | 1 | 1 selects `sync_bit_i` for the first bit, 0 selects P |
| sync_bit_i | input | 1 | S0+S1 sync indication |
| ser_o | output | 1 | Serial subcode output |

## Verification
The assertions check the following on every cycle:
- a load zeroes the pulse count;
- each detected shift edge below the limit raises the count by exactly one;
- a saturated count stays saturated;
- the output is stable on cycles with neither a load nor a shift;
- the first bit after a load matches the selected source.

Only the bench scenarios can show the full behaviour at the pins. This covers the bit order across a whole symbol through both synchronisers, the overrun level after extra pulses, and the absence of a reload on a falling frame-clock edge. It also covers the indifference to input changes made after the load.

// File: rtl/subcode_pkg.sv
package subcode_pkg;
  localparam int unsigned SC_SYM_W       = 8;
  localparam int unsigned SC_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb rs_d = 1'b1;
    end else begin : g_many
      always_comb rs_d = {rs_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_n_o = rs_q[STAGES-1];
endmodule

// File: rtl/sc_edge.sv
module sc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic lvl_w;
  logic prev_q;

  sc_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_i),
    .q_o   (lvl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_w;
  end

  assign rise_o = lvl_w & ~prev_q;
endmodule

// File: rtl/sc_shifter.sv
module sc_shifter #(
  parameter int unsigned SYM_W = 8,
  localparam int unsigned CNT_W = $clog2(SYM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             sync_flag_i,
  input  logic             sync_bit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ser_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(SYM_W);

  logic [SYM_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             head_w;
  logic             sh_en, cnt_en;

  // first-bit source selected once, at load time
  assign head_w = sync_flag_i ? sync_bit_i : sym_i[SYM_W-1];

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    sh_en  = 1'b0;
    cnt_en = 1'b0;
    if (load_i) begin
      sh_d   = {head_w, sym_i[SYM_W-2:0]};
      cnt_d  = '0;
      sh_en  = 1'b1;
      cnt_en = 1'b1;
    end else if (shift_i && (cnt_q < CNT_LIM)) begin
      sh_d   = {sh_q[SYM_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
      sh_en  = 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // reset to the saturated value: output low until the first load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_LIM;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ser_o = (cnt_q >= CNT_LIM) ? 1'b0 : sh_q[SYM_W-1];
endmodule

// File: rtl/subcode_serializer.sv
module subcode_serializer
  import subcode_pkg::*;
#(
  parameter int unsigned SYM_W       = SC_SYM_W,
  parameter int unsigned SYNC_STAGES = SC_SYNC_STAGES,
  localparam int unsigned CNT_W = $clog2(SYM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk_i,
  input  logic             shift_clk_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             sync_flag_i,
  input  logic             sync_bit_i,
  output logic             ser_o
);
  logic             rst_n_s;
  logic             load_w;
  logic             shift_w;
  logic [CNT_W-1:0] cnt_w;

  sc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sc_edge #(.STAGES(SYNC_STAGES)) u_frame_edge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (frame_clk_i),
    .rise_o  (load_w)
  );

  sc_edge #(.STAGES(SYNC_STAGES)) u_shift_edge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (shift_clk_i),
    .rise_o  (shift_w)
  );

  sc_shifter #(.SYM_W(SYM_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_i      (load_w),
    .shift_i     (shift_w),
    .sym_i       (sym_i),
    .sync_flag_i (sync_flag_i),
    .sync_bit_i  (sync_bit_i),
    .cnt_o       (cnt_w),
    .ser_o       (ser_o)
  );
endmodule

// File: rtl/subcode_serializer_chk.sv
module subcode_serializer_chk #(
  parameter int unsigned SYM_W = 8,
  localparam int unsigned CNT_W = $clog2(SYM_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             shift,
  input logic [CNT_W-1:0] cnt,
  input logic [SYM_W-1:0] sym_i,
  input logic             sync_flag_i,
  input logic             sync_bit_i,
  input logic             ser_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(SYM_W);

  logic seen_load_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_load_q <= 1'b0;
    else if (load) seen_load_q <= 1'b1;
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load_q |-> (ser_o == 1'b0));

  p_head_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sync_flag_i) |=> (ser_o == $past(sym_i[SYM_W-1])));

  p_head_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sync_flag_i) |=> (ser_o == $past(sync_bit_i)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load && (cnt < LIM)) |=> (cnt == $past(cnt) + 1'b1));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == LIM) && !load) |=> (cnt == LIM));

  p_load_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_load_q && !load && !shift) |=> $stable(ser_o));
endmodule

bind subcode_serializer subcode_serializer_chk #(.SYM_W(SYM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load        (load_w),
  .shift       (shift_w),
  .cnt         (cnt_w),
  .sym_i       (sym_i),
  .sync_flag_i (sync_flag_i),
  .sync_bit_i  (sync_bit_i),
  .ser_o       (ser_o)
);

// File: tb/test_subcode_serializer.sv
`timescale 1ns/1ps
module test_subcode_serializer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_clk_i;
  logic       shift_clk_i;
  logic [7:0] sym_i;
  logic       sync_flag_i;
  logic       sync_bit_i;
  logic       ser_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic val; string tag; } exp_t;
  exp_t exp_q[$];
  event smp;

  always #2.5 clk = ~clk;

  subcode_serializer i_subcode_serializer (
    .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk_i),
    .shift_clk_i(shift_clk_i), .sym_i(sym_i), .sync_flag_i(sync_flag_i),
    .sync_bit_i(sync_bit_i), .ser_o(ser_o)
  );

  // monitor: pops one expected item per sampling event and compares
  initial begin
    forever begin
      @(smp);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (ser_o !== e.val) begin
          errors++;
          $display("FAIL %s: ser_o=%b expected=%b at %0t", e.tag, ser_o, e.val, $time);
        end
      end
    end
  end

  task automatic expect_bit(input logic v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    -> smp;
    #0.1;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_shift();
    shift_clk_i = 1'b1; wait_clk(4);
    shift_clk_i = 1'b0; wait_clk(4);
  endtask

  task automatic load_frame(input logic [7:0] s, input logic f, input logic b);
    frame_clk_i = 1'b0; wait_clk(4);
    sym_i = s; sync_flag_i = f; sync_bit_i = b;
    frame_clk_i = 1'b1;
    wait_clk(3);
  endtask

  // full frame: first bit, seven shifted bits, then extra pulses in overrun
  task automatic run_frame(input logic [7:0] s, input logic f, input logic b, input int extra);
    load_frame(s, f, b);
    expect_bit(f ? b : s[7], f ? "R4 first bit is sync" : "R3 first bit is P");
    for (int i = 6; i >= 0; i--) begin
      pulse_shift();
      expect_bit(s[i], "R5 shift order");
    end
    for (int k = 0; k < extra; k++) begin
      pulse_shift();
      expect_bit(1'b0, "R6 overrun low");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_clk_i = 1'b0; shift_clk_i = 1'b0;
    sym_i = 8'h00; sync_flag_i = 1'b0; sync_bit_i = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    expect_bit(1'b0, "R1 reset level");
    sym_i = 8'hFF;
    pulse_shift();
    expect_bit(1'b0, "R1 no data before first load");

    run_frame(8'hA5, 1'b0, 1'b1, 3);
    run_frame(8'h3C, 1'b1, 1'b1, 1);
    run_frame(8'hFF, 1'b1, 1'b0, 2);
    // R7: new frame after overrun restarts at first bit
    run_frame(8'h96, 1'b0, 1'b0, 1);

    // R8: input changes after load are ignored; R2: falling edge does not reload
    load_frame(8'h81, 1'b0, 1'b0);
    expect_bit(1'b1, "R2 load on rising edge");
    sym_i = 8'h00; sync_flag_i = 1'b1; sync_bit_i = 1'b0;
    wait_clk(4);
    expect_bit(1'b1, "R8 input change ignored");
    pulse_shift();
    expect_bit(1'b0, "R8 bit Q from loaded symbol");
    frame_clk_i = 1'b0;
    wait_clk(6);
    expect_bit(1'b0, "R2 falling edge no reload");
    for (int i = 5; i >= 0; i--) begin
      pulse_shift();
      expect_bit(i == 0 ? 1'b1 : 1'b0, "R5 shift order after idle");
    end
    pulse_shift();
    expect_bit(1'b0, "R6 overrun low");
    load_frame(8'h7E, 1'b0, 1'b1);
    expect_bit(1'b0, "R7 restart after overrun");
    pulse_shift();
    expect_bit(1'b1, "R7 count cleared by load");

    wait_clk(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule